// File: doc/BRIEF.md
# Character LCD Host Bus Port

This block is the side of a character LCD controller that faces the host microprocessor. The host drives a register-select line, a read/write line and an enable strobe, and shares an 8-line bidirectional data bus with the block. The block brings the enable strobe into the internal clock domain and captures each transfer when enable falls. It sorts every transfer into one of four kinds: instruction write, status read, data write or data read.

Completed instruction and data bytes go to the internal engine over a valid/ready handshake. For reads, the block drives the bus with a status byte or with the engine's read data. The status byte holds the busy flag and the address counter. After each byte of read data it sends the engine a one-cycle advance pulse.

The bus can run 8 bits wide, or as pairs of 4-bit transfers on the upper four lines. The width is switched at run time by a bit in the function-set instruction.

Top module: `lcd_host_port`

## Requirements
- R1: After reset the bus width is 8 bits, the nibble phase points at the high half, `xfer_valid`, `eng_rnext` and `drop_err` are 0, and the block does not drive `bus_db`.
- R2: A completed transfer with `bus_rs`=0 and `bus_rw`=0 is offered as an instruction byte (`xfer_is_data`=0). One with `bus_rs`=1 and `bus_rw`=0 is offered as a data byte (`xfer_is_data`=1). The busy flag does not block data bytes.
- R3: A read with `bus_rs`=0 returns a status byte: bit 7 is `eng_busy` and bits 6:0 are `eng_addr`. The host never reads back an instruction byte.
- R4: A read with `bus_rs`=1 returns `eng_rdata`. `eng_rnext` pulses for one cycle per complete byte read, and never after only the first half of a 4-bit read.
- R5: The block drives `bus_db` only while `bus_rw`=1 and `bus_en`=1.
- R6: An accepted instruction byte with bits 7:5 = 001 is a function set, and its bit 4 selects the width (1 = 8 bits, 0 = 4 bits). After any width change the next transfer is the high half.
- R7: In 4-bit mode a write takes two transfers. Lines 7:4 carry the high nibble first and then the low nibble, and lines 3:0 are ignored. No byte is offered after the first transfer.
- R8: In 4-bit mode a read takes two transfers. The first puts bits 7:4 of the byte on lines 7:4, the second puts bits 3:0 there, and lines 3:0 read 0 both times.
- R9: An instruction byte that completes while `eng_busy`=1 is discarded. It changes neither the width nor the handshake, and it sets `drop_err`, which stays set until reset.
- R10: `xfer_valid` stays 1 and `xfer_byte` stays unchanged until a cycle with `xfer_ready`=1. The offer is then withdrawn on the following cycle.
- R11: A write byte that completes while an earlier byte is still being offered is discarded and sets `drop_err`. The earlier byte stays unchanged.
- R12: A transfer takes effect only after `bus_en` falls. While enable stays high, nothing is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_rs | input | 1 | Host register select: 0 instruction/status, 1 data |
| bus_rw | input | 1 | Host direction: 1 read, 0 write |
| bus_en | input | 1 | Host enable strobe (asynchronous) |
| bus_db | inout | 8 | Shared host data bus |
| eng_busy | input | 1 | Engine busy flag |
| eng_addr | input | 7 | Engine address counter |
| eng_rdata | input | 8 | Engine read data for the current address |
| eng_rnext | output | 1 | One-cycle pulse: read byte consumed |
| xfer_valid | output | 1 | A write byte is offered to the engine |
| xfer_is_data | output | 1 | Offered byte is data (1) or instruction (0) |
| xfer_byte | output | 8 | Offered byte |
| xfer_ready | input | 1 | Engine takes the offered byte |
| drop_err | output | 1 | Sticky: a write byte was discarded |

## Verification
Two collisions matter here. The first is a finished write byte arriving while the previous offer is still held. The bench provokes it by keeping `xfer_ready` low across two writes, then checks that the first byte survives and `drop_err` rises. The second is a function-set instruction completing while the engine is busy. The bench writes it in 4-bit mode with `eng_busy` high, then shows that the width did not change: the next two-nibble data write still assembles one correct byte.

// File: rtl/lcd_host_pkg.sv
package lcd_host_pkg;
  localparam int BUS_W  = 8;
  localparam int NIB_W  = BUS_W / 2;
  localparam int ADDR_W = BUS_W - 1;

  typedef enum logic {WIDTH_4 = 1'b0, WIDTH_8 = 1'b1} width_e;

  typedef struct packed {
    logic             rs;
    logic             rw;
    logic [BUS_W-1:0] db;
  } bus_cap_t;

  // Status byte: busy on the top line, address counter below it.
  function automatic logic [BUS_W-1:0] status_pack(input logic busy,
                                                   input logic [ADDR_W-1:0] addr);
    return {busy, addr};
  endfunction

  // Places one half of a byte on the upper lanes, lower lanes zero.
  function automatic logic [BUS_W-1:0] upper_lane(input logic [BUS_W-1:0] b,
                                                  input logic low_half);
    logic [NIB_W-1:0] n;
    n = low_half ? b[NIB_W-1:0] : b[BUS_W-1:NIB_W];
    return {n, {NIB_W{1'b0}}};
  endfunction

  // Function set: top three bits 001.
  function automatic logic is_func_set(input logic [BUS_W-1:0] b);
    return b[BUS_W-1:BUS_W-3] == 3'b001;
  endfunction
endpackage

// File: rtl/lcd_strobe_sync.sv
module lcd_strobe_sync
  import lcd_host_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             rs_i,
  input  logic             rw_i,
  input  logic [BUS_W-1:0] db_i,
  output logic             fall_o,
  output bus_cap_t         cap_o
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] e_sr;
  logic                   e_last;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) e_sr <= '0;
        else        e_sr <= en_i;
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) e_sr <= '0;
        else        e_sr <= {e_sr[SYNC_STAGES-2:0], en_i};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_last <= 1'b0;
      cap_o  <= '0;
    end else begin
      e_last <= e_sr[LAST];
      // Bus lines are sampled while the strobe is seen high.
      if (e_sr[0]) cap_o <= '{rs: rs_i, rw: rw_i, db: db_i};
    end
  end

  assign fall_o = e_last & ~e_sr[LAST];
endmodule

// File: rtl/lcd_nibble_pack.sv
module lcd_nibble_pack
  import lcd_host_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fall_i,
  input  bus_cap_t         cap_i,
  input  logic             set_w_i,
  input  width_e           new_w_i,
  output width_e           width_o,
  output logic             phase_o,
  output logic             done_o,
  output logic [BUS_W-1:0] byte_o
);
  logic [NIB_W-1:0] hi_q;
  logic             wide;

  assign wide    = (width_o == WIDTH_8);
  assign done_o  = fall_i & (wide | phase_o);
  assign byte_o  = wide ? cap_i.db : {hi_q, cap_i.db[BUS_W-1:NIB_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_o <= WIDTH_8;
      phase_o <= 1'b0;
      hi_q    <= '0;
    end else if (set_w_i && new_w_i != width_o) begin
      width_o <= new_w_i;
      phase_o <= 1'b0;
    end else if (fall_i && !wide) begin
      phase_o <= ~phase_o;
      if (!phase_o) hi_q <= cap_i.db[BUS_W-1:NIB_W];
    end
  end

  // R6
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !set_w_i |=> $stable(width_o));

  // R6
  phase_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (set_w_i && new_w_i != width_o) |=> !phase_o);
endmodule

// File: rtl/lcd_bus_drive.sv
module lcd_bus_drive
  import lcd_host_pkg::*;
(
  input  logic              en_i,
  input  logic              rw_i,
  input  logic              rs_i,
  input  logic              busy_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BUS_W-1:0]  rdata_i,
  input  width_e            width_i,
  input  logic              phase_i,
  output logic              oe_o,
  output logic [BUS_W-1:0]  db_o
);
  logic [BUS_W-1:0] full;

  assign full = rs_i ? rdata_i : status_pack(busy_i, addr_i);
  assign oe_o = rw_i & en_i;
  assign db_o = (width_i == WIDTH_8) ? full : upper_lane(full, phase_i);
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
  import lcd_host_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rs,
  input  logic             bus_rw,
  input  logic             bus_en,
  inout  wire  [7:0]       bus_db,
  input  logic             eng_busy,
  input  logic [6:0]       eng_addr,
  input  logic [7:0]       eng_rdata,
  output logic             eng_rnext,
  output logic             xfer_valid,
  output logic             xfer_is_data,
  output logic [7:0]       xfer_byte,
  input  logic             xfer_ready,
  output logic             drop_err
);
  logic             fall_w;
  bus_cap_t         cap_w;
  width_e           width_w;
  logic             phase_w;
  logic             done_w;
  logic [BUS_W-1:0] byte_w;
  logic             oe_w;
  logic [BUS_W-1:0] dout_w;

  // Named events for the assertions.
  logic ins_done_w, dat_done_w, rd_done_w, wr_done_w;
  logic accept_w, drop_w, set_w;

  lcd_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .en_i(bus_en), .rs_i(bus_rs), .rw_i(bus_rw),
    .db_i(bus_db), .fall_o(fall_w), .cap_o(cap_w));

  assign ins_done_w = done_w & ~cap_w.rs & ~cap_w.rw;
  assign dat_done_w = done_w &  cap_w.rs & ~cap_w.rw;
  assign rd_done_w  = done_w &  cap_w.rw;
  assign wr_done_w  = ins_done_w | dat_done_w;
  assign accept_w   = wr_done_w & ~xfer_valid & ~(ins_done_w & eng_busy);
  assign drop_w     = wr_done_w & ~accept_w;
  assign set_w      = accept_w & ins_done_w & is_func_set(byte_w);

  lcd_nibble_pack u_pack (
    .clk(clk), .rst_n(rst_n), .fall_i(fall_w), .cap_i(cap_w),
    .set_w_i(set_w), .new_w_i(width_e'(byte_w[4])),
    .width_o(width_w), .phase_o(phase_w), .done_o(done_w), .byte_o(byte_w));

  lcd_bus_drive u_drive (
    .en_i(bus_en), .rw_i(bus_rw), .rs_i(bus_rs), .busy_i(eng_busy),
    .addr_i(eng_addr), .rdata_i(eng_rdata), .width_i(width_w),
    .phase_i(phase_w), .oe_o(oe_w), .db_o(dout_w));

  assign bus_db = oe_w ? dout_w : 8'bz;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      xfer_valid   <= 1'b0;
      xfer_is_data <= 1'b0;
      xfer_byte    <= '0;
      drop_err     <= 1'b0;
      eng_rnext    <= 1'b0;
    end else begin
      eng_rnext <= rd_done_w & cap_w.rs;
      if (drop_w) drop_err <= 1'b1;
      if (accept_w) begin
        xfer_valid   <= 1'b1;
        xfer_is_data <= cap_w.rs;
        xfer_byte    <= byte_w;
      end else if (xfer_valid && xfer_ready) begin
        xfer_valid <= 1'b0;
      end
    end
  end

  // R10
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_valid && !xfer_ready) |=> (xfer_valid && $stable(xfer_byte)));

  // R9
  busy_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_done_w && eng_busy) |=> drop_err);

  // R11
  pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_done_w && xfer_valid && !xfer_ready) |=> (drop_err && $stable(xfer_byte)));

  // R2
  data_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_done_w && !xfer_valid) |=> (xfer_valid && xfer_is_data));

  // R4
  rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_done_w && cap_w.rs) |=> eng_rnext);

  // R9
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_err |=> drop_err);
endmodule

// File: tb/lcd_host_port_bench.sv
module lcd_host_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_rs = 1'b0, bus_rw = 1'b0, bus_en = 1'b0;
  logic [7:0] host_db = 8'h00;
  logic       host_oe = 1'b0;
  wire  [7:0] bus_db;
  logic       eng_busy = 1'b0;
  logic [6:0] eng_addr = 7'h00;
  logic [7:0] eng_rdata = 8'h00;
  logic       eng_rnext, xfer_valid, xfer_is_data, drop_err;
  logic [7:0] xfer_byte;
  logic       xfer_ready = 1'b0;

  int n_chk = 0, n_fail = 0, rn_cnt = 0;

  always #10 clk = ~clk;
  assign bus_db = host_oe ? host_db : 8'bz;

  lcd_host_port u_lcd_host_port (
    .clk(clk), .rst_n(rst_n), .bus_rs(bus_rs), .bus_rw(bus_rw), .bus_en(bus_en),
    .bus_db(bus_db), .eng_busy(eng_busy), .eng_addr(eng_addr),
    .eng_rdata(eng_rdata), .eng_rnext(eng_rnext), .xfer_valid(xfer_valid),
    .xfer_is_data(xfer_is_data), .xfer_byte(xfer_byte),
    .xfer_ready(xfer_ready), .drop_err(drop_err));

  always @(posedge clk) if (rst_n && eng_rnext) rn_cnt <= rn_cnt + 1;

  typedef struct packed {
    logic       rs;
    logic       busy;
    logic [7:0] b;
    logic       ok;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{rs: 1'b0, busy: 1'b0, b: 8'h01, ok: 1'b1},
    '{rs: 1'b1, busy: 1'b0, b: 8'h41, ok: 1'b1},
    '{rs: 1'b0, busy: 1'b1, b: 8'h0C, ok: 1'b0},
    '{rs: 1'b1, busy: 1'b1, b: 8'hA5, ok: 1'b1},
    '{rs: 1'b0, busy: 1'b0, b: 8'h80, ok: 1'b1},
    '{rs: 1'b1, busy: 1'b0, b: 8'h00, ok: 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; bus_en = 1'b0; host_oe = 1'b0; xfer_ready = 1'b0; eng_busy = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic wr(input logic rs, input logic [7:0] v);
    @(negedge clk);
    bus_rs = rs; bus_rw = 1'b0; host_db = v; host_oe = 1'b1;
    @(negedge clk); bus_en = 1'b1;
    repeat (4) @(negedge clk); bus_en = 1'b0;
    repeat (2) @(negedge clk); host_oe = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic rs, output logic [7:0] v);
    @(negedge clk);
    bus_rs = rs; bus_rw = 1'b1; host_oe = 1'b0;
    @(negedge clk); bus_en = 1'b1;
    repeat (2) @(negedge clk); v = bus_db;
    repeat (2) @(negedge clk); bus_en = 1'b0;
    repeat (6) @(negedge clk);
    bus_rw = 1'b0;
  endtask

  task automatic take();
    @(negedge clk); xfer_ready = 1'b1;
    @(negedge clk); xfer_ready = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] r;
    logic       err_exp;
    int         rn0;
    do_reset();
    // R1: reset state
    chk("R1 valid", {7'd0, xfer_valid}, 8'h00);
    chk("R1 err", {7'd0, drop_err}, 8'h00);
    chk("R1 rnext", {7'd0, eng_rnext}, 8'h00);
    // R1 / R5: block silent while idle, host value seen unchanged
    bus_rw = 1'b1; host_db = 8'h5A; host_oe = 1'b1;
    @(negedge clk); chk("R5 idle rw=1 en=0", bus_db, 8'h5A);
    bus_rw = 1'b0; bus_en = 1'b1; host_db = 8'hC3;
    @(negedge clk); chk("R5 write en=1", bus_db, 8'hC3);
    bus_en = 1'b0; host_oe = 1'b0;
    do_reset();

    // R2 / R9 / R10 table, 8-bit mode after reset (R1)
    err_exp = 1'b0;
    foreach (VEC[i]) begin
      eng_busy = VEC[i].busy;
      wr(VEC[i].rs, VEC[i].b);
      chk("R2 valid", {7'd0, xfer_valid}, {7'd0, VEC[i].ok});
      if (VEC[i].ok) begin
        chk("R2 kind", {7'd0, xfer_is_data}, {7'd0, VEC[i].rs});
        chk("R2 byte", xfer_byte, VEC[i].b);
      end else err_exp = 1'b1;
      chk("R9 err", {7'd0, drop_err}, {7'd0, err_exp});
      repeat (3) @(negedge clk);
      chk("R10 still offered", {7'd0, xfer_valid}, {7'd0, VEC[i].ok});
      take();
      chk("R10 withdrawn", {7'd0, xfer_valid}, 8'h00);
    end
    eng_busy = 1'b0;

    // R3 / R4 in 8-bit mode
    eng_busy = 1'b1; eng_addr = 7'h23;
    rd(1'b0, r); chk("R3 status 8-bit", r, 8'hA3);
    eng_busy = 1'b0;
    eng_rdata = 8'hC3; rn0 = rn_cnt;
    rd(1'b1, r); chk("R4 data 8-bit", r, 8'hC3);
    chk("R4 one pulse", 8'(rn_cnt - rn0), 8'd1);

    // R11: second byte while first is pending
    do_reset();
    wr(1'b1, 8'h11);
    wr(1'b1, 8'h22);
    chk("R11 first kept", xfer_byte, 8'h11);
    chk("R11 err", {7'd0, drop_err}, 8'h01);
    take();
    chk("R11 no second offer", {7'd0, xfer_valid}, 8'h00);

    // R12: nothing while enable is high
    do_reset();
    @(negedge clk);
    bus_rs = 1'b1; bus_rw = 1'b0; host_db = 8'h99; host_oe = 1'b1; bus_en = 1'b1;
    repeat (6) @(negedge clk);
    chk("R12 held high", {7'd0, xfer_valid}, 8'h00);
    bus_en = 1'b0;
    repeat (2) @(negedge clk); host_oe = 1'b0;
    repeat (3) @(negedge clk);
    chk("R12 after fall", xfer_byte, 8'h99);
    take();

    // R6: switch to 4-bit
    wr(1'b0, 8'h28);
    chk("R6 func set offered", xfer_byte, 8'h28);
    take();
    // R7: two nibbles, low lanes junk
    wr(1'b1, 8'h3F);
    chk("R7 no byte after half", {7'd0, xfer_valid}, 8'h00);
    wr(1'b1, 8'hC5);
    chk("R7 assembled", xfer_byte, 8'h3C);
    chk("R7 kind", {7'd0, xfer_is_data}, 8'h01);
    take();
    // R8 / R3: status in halves
    eng_busy = 1'b1; eng_addr = 7'h5A;
    rd(1'b0, r); chk("R8 status high half", r, 8'hD0);
    rd(1'b0, r); chk("R8 status low half", r, 8'hA0);
    eng_busy = 1'b0;
    // R4 / R8: data read in halves
    eng_rdata = 8'h96; rn0 = rn_cnt;
    rd(1'b1, r); chk("R8 data high half", r, 8'h90);
    chk("R4 no pulse after half", 8'(rn_cnt - rn0), 8'd0);
    rd(1'b1, r); chk("R8 data low half", r, 8'h60);
    chk("R4 pulse after byte", 8'(rn_cnt - rn0), 8'd1);
    // R9: busy function set is discarded, width unchanged
    eng_busy = 1'b1;
    wr(1'b0, 8'h30); wr(1'b0, 8'h80);
    chk("R9 not offered", {7'd0, xfer_valid}, 8'h00);
    chk("R9 err", {7'd0, drop_err}, 8'h01);
    eng_busy = 1'b0;
    wr(1'b1, 8'h70);
    chk("R9 still 4-bit", {7'd0, xfer_valid}, 8'h00);
    wr(1'b1, 8'hE0);
    chk("R9 4-bit byte", xfer_byte, 8'h7E);
    take();
    // R6: back to 8-bit
    wr(1'b0, 8'h30); wr(1'b0, 8'h0F);
    chk("R6 func set 8", xfer_byte, 8'h30);
    take();
    wr(1'b1, 8'h5B);
    chk("R6 single transfer", xfer_byte, 8'h5B);
    chk("R6 valid", {7'd0, xfer_valid}, 8'h01);
    take();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule